// File: doc/BRIEF.md
# Outbound Request Header Generator

This block turns one translated outbound request into the header of a PCI Express request packet, delivered as 32-bit double words (DWs). Each request names its kind (memory read, memory write, I/O read or I/O write) and carries a 36-bit address, a length, a tag and first/last byte enables. The block picks the header size from the address value at run time. Any address at or above 4 GiB takes the four-DW form; every other address takes the three-DW form. It fills in the format and type fields and streams the DWs out, marking the final one with a last flag.

I/O requests follow stricter rules. They are only legal while the root-complex mode input is high. They are always sent as three-DW headers with a length of one DW and the last byte enables cleared. An I/O request that is not legal is still consumed, but it produces no output. Instead, a one-cycle error pulse follows its acceptance.

Both streaming edges are valid/ready. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while no header is in flight, so exactly one request is outstanding at a time. A DW transfers on an edge where `dw_valid` and `dw_ready` are both high. The sink may hold `dw_ready` low for any number of cycles, and the DW on offer stays unchanged until it is taken.

Top module: `tlp_hdr_gen`

## Requirements
- R1: A memory request with addr[35:32] == 0 yields exactly 3 DWs: DW0 bit 29 (address-size flag) is 0, and DW2 is {addr[31:2], 2'b00}.
- R2: A memory request with addr[35:32] != 0 yields exactly 4 DWs: DW0 bit 29 is 1, DW2 is the zero-extended addr[35:32], and DW3 is {addr[31:2], 2'b00}.
- R3: The type field DW0[28:24] is 5'b00000 for memory requests. DW0 bit 30 (write flag) is 0 for a read (kind 0) and 1 for a write (kind 1).
- R4: For I/O requests DW0[28:24] is 5'b00010. DW0 bit 30 is 0 for an I/O read (kind 2) and 1 for an I/O write (kind 3). The header is always 3 DWs with DW0 bit 29 = 0.
- R5: An I/O header has length field DW0[9:0] = 1 and last byte enables DW1[7:4] = 0. Its first byte enables DW1[3:0] come from the request.
- R6: An I/O request accepted while rc_mode is low, or with addr[35:32] != 0, produces no DW. req_err is high for exactly the one cycle after its acceptance.
- R7: DW1 is {REQ_ID[15:0], tag[7:0], last_be[3:0], first_be[3:0]}. A memory header carries the request length unchanged in DW0[9:0]. DW0[31] and DW0[23:10] are zero.
- R8: dw_last is high on the final DW of a header and low on every other DW.
- R9: While dw_valid is high and dw_ready is low, dw_valid, dw_data and dw_last hold their values into the next cycle.
- R10: req_ready is low from the acceptance of a legal request until the cycle after its last DW is taken. A request held valid meanwhile is accepted only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rc_mode | input | 1 | High when the controller acts as root complex; permits I/O requests |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken (no header in flight) |
| req_kind | input | 2 | 0 memory read, 1 memory write, 2 I/O read, 3 I/O write |
| req_addr | input | 36 | Translated byte address |
| req_len | input | 10 | Payload length in DWs (memory requests) |
| req_tag | input | 8 | Transaction tag |
| req_first_be | input | 4 | First DW byte enables |
| req_last_be | input | 4 | Last DW byte enables |
| dw_valid | output | 1 | Header DW offered |
| dw_ready | input | 1 | Sink takes the offered DW |
| dw_data | output | 32 | Header DW |
| dw_last | output | 1 | Offered DW is the final one of the header |
| req_err | output | 1 | One-cycle pulse: last accepted request was refused |

## Verification
Two functions can meet on the same edge. One is the final handshake of a header. The other is the acceptance of the next request, which only becomes possible once that handshake has taken place. The bench provokes this with back-to-back requests: the second request is held valid throughout the first header, and the sink stalls at random, including on the last DW. The bench then judges three things. `req_ready` must stay low while any DW is offered. The held request must be taken exactly once, right after the last DW. Its header must follow intact with no merged or lost DW. Refused I/O requests placed directly after a header, and between legal ones, also check that the error pulse never overlaps a DW in flight.

// File: rtl/tlp_hdr_pkg.sv
package tlp_hdr_pkg;
  localparam int LEN_W  = 10;
  localparam int TAG_W  = 8;
  localparam int BE_W   = 4;
  localparam int DW_W   = 32;
  localparam int NDW_MAX = 4;

  typedef enum logic [1:0] {
    KIND_MRD  = 2'd0,
    KIND_MWR  = 2'd1,
    KIND_IORD = 2'd2,
    KIND_IOWR = 2'd3
  } req_kind_e;

  localparam logic [4:0] TYPE_MEM = 5'b00000;
  localparam logic [4:0] TYPE_IO  = 5'b00010;

  typedef struct packed {
    logic [1:0] fmt;
    logic [4:0] ty;
    logic       four_dw;
    logic       is_io;
    logic       reject;
  } req_class_t;
endpackage

// File: rtl/tlp_req_classify.sv
module tlp_req_classify
  import tlp_hdr_pkg::*;
#(
  parameter int ADDR_W = 36
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rc_mode,
  output req_class_t        cls
);
  logic above_4g;
  logic io_kind;
  logic wr_kind;

  always_comb begin
    above_4g    = |addr[ADDR_W-1:32];
    io_kind     = (kind == KIND_IORD) || (kind == KIND_IOWR);
    wr_kind     = (kind == KIND_MWR)  || (kind == KIND_IOWR);
    cls.is_io   = io_kind;
    cls.four_dw = !io_kind && above_4g;
    cls.fmt     = {wr_kind, cls.four_dw};
    cls.ty      = io_kind ? TYPE_IO : TYPE_MEM;
    cls.reject  = io_kind && (!rc_mode || above_4g);
  end
endmodule

// File: rtl/tlp_hdr_pack.sv
module tlp_hdr_pack
  import tlp_hdr_pkg::*;
#(
  parameter int          ADDR_W = 36,
  parameter logic [15:0] REQ_ID = 16'h0100
) (
  input  req_class_t                  cls,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LEN_W-1:0]            len,
  input  logic [TAG_W-1:0]            tag,
  input  logic [BE_W-1:0]             first_be,
  input  logic [BE_W-1:0]             last_be,
  output logic [NDW_MAX-1:0][DW_W-1:0] hdr
);
  localparam int UPPER_W = ADDR_W - 32;

  logic [LEN_W-1:0] len_eff;
  logic [BE_W-1:0]  lbe_eff;
  logic [DW_W-1:0]  addr_lo;
  logic [DW_W-1:0]  addr_hi;

  always_comb begin
    len_eff = cls.is_io ? LEN_W'(1) : len;
    lbe_eff = cls.is_io ? '0 : last_be;
    addr_lo = {addr[31:2], 2'b00};
    addr_hi = {{(DW_W-UPPER_W){1'b0}}, addr[ADDR_W-1:32]};
    hdr[0]  = {1'b0, cls.fmt, cls.ty, 14'd0, len_eff};
    hdr[1]  = {REQ_ID, tag, lbe_eff, first_be};
    hdr[2]  = cls.four_dw ? addr_hi : addr_lo;
    hdr[3]  = addr_lo;
  end
endmodule

// File: rtl/tlp_dw_sequencer.sv
module tlp_dw_sequencer
  import tlp_hdr_pkg::*;
#(
  parameter int N = NDW_MAX
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic                  load_four,
  input  logic [N-1:0][DW_W-1:0] hdr_in,
  input  logic                  dw_ready,
  output logic                  busy,
  output logic                  dw_valid,
  output logic [DW_W-1:0]       dw_data,
  output logic                  dw_last
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0][DW_W-1:0] hdr_q;
  logic [IDX_W-1:0]       idx_q;
  logic [IDX_W-1:0]       end_q;
  logic                   busy_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    hdr_q[g] <= '0;
      else if (load) hdr_q[g] <= hdr_in[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      end_q  <= '0;
    end else if (load) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      end_q  <= load_four ? IDX_W'(N-1) : IDX_W'(N-2);
    end else if (busy_q && dw_ready) begin
      if (idx_q == end_q) busy_q <= 1'b0;
      else                idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy     = busy_q;
  assign dw_valid = busy_q;
  assign dw_data  = hdr_q[idx_q];
  assign dw_last  = busy_q && (idx_q == end_q);
endmodule

// File: rtl/tlp_hdr_gen.sv
module tlp_hdr_gen
  import tlp_hdr_pkg::*;
#(
  parameter int          ADDR_W = 36,
  parameter logic [15:0] REQ_ID = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rc_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [9:0]        req_len,
  input  logic [7:0]        req_tag,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  output logic              dw_valid,
  input  logic              dw_ready,
  output logic [31:0]       dw_data,
  output logic              dw_last,
  output logic              req_err
);
  req_class_t                    cls;
  logic [NDW_MAX-1:0][DW_W-1:0]  hdr;
  logic                          busy;
  logic                          accept;
  logic                          err_q;

  tlp_req_classify #(.ADDR_W(ADDR_W)) u_cls (
    .kind    (req_kind),
    .addr    (req_addr),
    .rc_mode (rc_mode),
    .cls     (cls)
  );

  tlp_hdr_pack #(.ADDR_W(ADDR_W), .REQ_ID(REQ_ID)) u_pack (
    .cls      (cls),
    .addr     (req_addr),
    .len      (req_len),
    .tag      (req_tag),
    .first_be (req_first_be),
    .last_be  (req_last_be),
    .hdr      (hdr)
  );

  assign accept    = req_valid && req_ready;
  assign req_ready = !busy;

  tlp_dw_sequencer #(.N(NDW_MAX)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept && !cls.reject),
    .load_four (cls.four_dw),
    .hdr_in    (hdr),
    .dw_ready  (dw_ready),
    .busy      (busy),
    .dw_valid  (dw_valid),
    .dw_data   (dw_data),
    .dw_last   (dw_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && cls.reject;
  end

  assign req_err = err_q;
endmodule

// File: rtl/tlp_hdr_gen_chk.sv
module tlp_hdr_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        dw_valid,
  input logic        dw_ready,
  input logic [31:0] dw_data,
  input logic        dw_last,
  input logic        req_err
);
  logic [1:0] beat;
  logic       fmt0_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat   <= '0;
      fmt0_q <= 1'b0;
    end else if (dw_valid && dw_ready) begin
      if (beat == 2'd0) fmt0_q <= dw_data[29];
      beat <= dw_last ? 2'd0 : beat + 2'd1;
    end
  end

  AST_BUSY_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid |-> !req_ready); // R10

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && !dw_ready |=> dw_valid && $stable(dw_data) && $stable(dw_last)); // R9

  AST_ERR_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !dw_valid); // R6

  AST_IO_SHORT_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && beat == 2'd0 && dw_data[28:24] == 5'b00010 |-> !dw_data[29] && dw_data[9:0] == 10'd1); // R4

  AST_LAST_POSITION: assert property (@(posedge clk) disable iff (!rst_n)
    dw_valid && dw_last |-> beat == (fmt0_q ? 2'd3 : 2'd2)); // R8
endmodule

bind tlp_hdr_gen tlp_hdr_gen_chk u_chk (.*);

// File: tb/tb_tlp_hdr_gen.sv
module tb_tlp_hdr_gen;
  localparam logic [15:0] RID = 16'h0100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rc_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [35:0] req_addr = '0;
  logic [9:0]  req_len = '0;
  logic [7:0]  req_tag = '0;
  logic [3:0]  req_first_be = '0;
  logic [3:0]  req_last_be = '0;
  logic        dw_valid;
  logic        dw_ready = 1'b0;
  logic [31:0] dw_data;
  logic        dw_last;
  logic        req_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic        e_bad;
  int          e_n;
  logic [31:0] e_dw [4];
  logic        e_io;

  always #10 clk = ~clk;

  tlp_hdr_gen #(.ADDR_W(36), .REQ_ID(RID)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_hdr(input logic [1:0] k, input logic [35:0] a, input logic [9:0] l,
                            input logic [7:0] t, input logic [3:0] fb, input logic [3:0] lb,
                            input logic rc);
    logic hi;
    logic wr;
    hi   = (a[35:32] != 4'h0);
    wr   = k[0];
    e_io = k[1];
    e_bad = e_io && (!rc || hi);
    e_n  = (!e_io && hi) ? 4 : 3;
    e_dw[0] = {1'b0, wr, (!e_io && hi), (e_io ? 5'b00010 : 5'b00000), 14'd0, (e_io ? 10'd1 : l)};
    e_dw[1] = {RID, t, (e_io ? 4'h0 : lb), fb};
    if (e_n == 4) begin
      e_dw[2] = {28'd0, a[35:32]};
      e_dw[3] = {a[31:2], 2'b00};
    end else begin
      e_dw[2] = {a[31:2], 2'b00};
      e_dw[3] = '0;
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [35:0] a, input logic [9:0] l,
                       input logic [7:0] t, input logic [3:0] fb, input logic [3:0] lb,
                       input logic rc);
    req_kind = k; req_addr = a; req_len = l; req_tag = t;
    req_first_be = fb; req_last_be = lb; rc_mode = rc; req_valid = 1'b1;
    expect_hdr(k, a, l, t, fb, lb, rc);
  endtask

  // At a negedge after acceptance; returns at a negedge after the final beat.
  task automatic collect(input int stall_pct);
    int i = 0;
    while (i < e_n) begin
      logic rdy;
      rdy = ($urandom % 100) >= stall_pct;
      dw_ready = rdy;
      #1;
      chk(dw_valid === 1'b1, "R1 dw_valid during header", 64'(dw_valid), 64'd1);
      chk(req_ready === 1'b0, "R10 req_ready low while busy", 64'(req_ready), 64'd0);
      if (rdy && dw_valid) begin
        string tg;
        if (i == 0)      tg = e_io ? "R4 R5 DW0" : "R3 R7 DW0";
        else if (i == 1) tg = "R5 R7 DW1";
        else             tg = (e_n == 4) ? "R2 address DW" : "R1 address DW";
        chk(dw_data === e_dw[i], tg, 64'(dw_data), 64'(e_dw[i]));
        chk(dw_last === (i == e_n - 1), "R8 dw_last", 64'(dw_last), 64'(i == e_n - 1));
        i++;
        @(posedge clk); @(negedge clk);
      end else begin
        logic [31:0] d;
        logic        ls;
        d = dw_data; ls = dw_last;
        @(posedge clk); @(negedge clk);
        chk(dw_valid === 1'b1 && dw_data === d && dw_last === ls, "R9 hold under stall",
            64'({dw_valid, dw_last, dw_data}), 64'({1'b1, ls, d}));
      end
    end
    dw_ready = 1'b0;
  endtask

  task automatic one_req(input logic [1:0] k, input logic [35:0] a, input logic [9:0] l,
                         input logic [7:0] t, input logic [3:0] fb, input logic [3:0] lb,
                         input logic rc, input int stall_pct);
    @(negedge clk);
    drive(k, a, l, t, fb, lb, rc);
    chk(req_ready === 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (e_bad) begin
      chk(req_err === 1'b1, "R6 error pulse", 64'(req_err), 64'd1);
      chk(dw_valid === 1'b0, "R6 no output", 64'(dw_valid), 64'd0);
      @(posedge clk); @(negedge clk);
      chk(req_err === 1'b0, "R6 pulse one cycle", 64'(req_err), 64'd0);
      chk(dw_valid === 1'b0, "R6 still no output", 64'(dw_valid), 64'd0);
    end else begin
      chk(req_err === 1'b0, "R6 no error on legal request", 64'(req_err), 64'd0);
      collect(stall_pct);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1 && dw_valid === 1'b0 && req_err === 1'b0 && dw_last === 1'b0,
        "R10 reset state", 64'({req_ready, dw_valid, req_err, dw_last}), 64'b1000);
    rst_n = 1'b1;

    // Directed corners
    one_req(2'd0, 36'h0_FFFF_FFFC, 10'd16, 8'h11, 4'hF, 4'h3, 1'b0, 0);  // R1 just below 4 GiB
    one_req(2'd1, 36'h1_0000_0000, 10'd0,  8'h22, 4'hF, 4'hF, 1'b0, 0);  // R2 exactly 4 GiB
    one_req(2'd1, 36'hF_1234_5678, 10'd5,  8'h33, 4'hC, 4'h1, 1'b1, 50); // R2 R3 write high
    one_req(2'd2, 36'h0_0000_0CF8, 10'd9,  8'h44, 4'h3, 4'hF, 1'b1, 0);  // R4 R5 I/O read
    one_req(2'd3, 36'h0_0000_0CFC, 10'd9,  8'h45, 4'hF, 4'hF, 1'b1, 60); // R4 R5 I/O write
    one_req(2'd2, 36'h0_0000_0CF8, 10'd1,  8'h46, 4'hF, 4'h0, 1'b0, 0);  // R6 not root complex
    one_req(2'd3, 36'h2_0000_0000, 10'd1,  8'h47, 4'hF, 4'h0, 1'b1, 0);  // R6 I/O above 4 GiB
    one_req(2'd3, 36'h1_0000_0000, 10'd1,  8'h48, 4'hF, 4'h0, 1'b1, 0);  // R6 back-to-back refusal

    // R10 back-to-back: second request held valid during first header
    @(negedge clk);
    drive(2'd0, 36'h3_0000_1000, 10'd7, 8'h55, 4'hF, 4'hF, 1'b0);
    @(posedge clk); @(negedge clk);
    begin
      logic [31:0] b_dw [4];
      int b_n;
      logic b_io;
      drive(2'd1, 36'h0_0000_2004, 10'd3, 8'h56, 4'h1, 4'h8, 1'b0);
      b_dw = e_dw; b_n = e_n; b_io = e_io;
      expect_hdr(2'd0, 36'h3_0000_1000, 10'd7, 8'h55, 4'hF, 4'hF, 1'b0);
      collect(40);
      chk(req_ready === 1'b1 && dw_valid === 1'b0, "R10 ready after last beat",
          64'({req_ready, dw_valid}), 64'b10);
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      e_dw = b_dw; e_n = b_n; e_io = b_io;
      collect(40);
      #1;
      chk(dw_valid === 1'b0, "R10 held request taken once", 64'(dw_valid), 64'd0);
    end

    // Constrained random
    for (int n = 0; n < 400; n++) begin
      logic [1:0]  k;
      logic [35:0] a;
      k = 2'($urandom);
      a = {(($urandom % 3) == 0) ? 4'($urandom) : 4'h0, 32'($urandom)};
      one_req(k, a, 10'($urandom), 8'($urandom), 4'($urandom), 4'($urandom),
              1'(($urandom % 4) != 0), int'($urandom % 70));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule